// File: doc/BRIEF.md
# SPI Receive Path with Selectable Zero-Extension

This block is the receive half of an SPI peripheral. Serial bits arrive one at a time, each one marked by a single-cycle strobe in the system clock domain. The bits shift into a 32-bit shift register. A three-state frame machine (`ST_IDLE`, `ST_SHIFT`, `ST_XFER`) counts the bits of each frame. When the programmed frame length has arrived, the machine spends one cycle in `ST_XFER`. In that cycle the finished word is copied into the readable receive data register, and the upper bits of the word are forced to zero on the way.

Two modes decide how many upper bits are cleared. In length mode (mask enable = 0), every bit above the frame length is cleared. In explicit mode (mask enable = 1), a separately programmed top-bit index sets the cut. Software programs both settings, and reads the received word, through a small single-cycle register port. A full flag reports that an unread word is waiting. An overrun flag reports that a later frame was dropped because the earlier word had not been read.

The frame machine has these transitions:
- idle→shift: first strobe of a frame, when the length is more than 1 bit.
- idle→xfer: first strobe when the length is exactly 1 bit.
- shift→xfer: last strobe of the frame.
- xfer→idle: no strobe in the transfer cycle.
- xfer→shift or xfer→xfer: a strobe arrives in the transfer cycle and starts the next frame.

Top module: `spi_rx_mask`

## Requirements
- R1: After reset, all of the following read 0: the data register (address 0), the control register (address 1), the mask register (address 2), `rx_full` and `rx_overrun`.
- R2: Mask register layout (address 2): the top-bit index is bits 14:10 and the mask enable is bit 1. All other bits read 0 whatever is written, so writing all ones reads back 0x00007C02.
- R3: Control register layout (address 1): the frame-length field is bits 14:10 and gives a frame of field+1 bits. All other bits read 0, so writing all ones reads back 0x00007C00.
- R4: On every strobe, the shift register moves up by one bit and takes `sdi` into bit 0, so the first bit received ends up as the most significant. The shift register is not cleared between frames. A frame completes on its field+1-th strobe.
- R5: With the enable at 0, the loaded word equals the shift register with every bit above the frame-length field value cleared.
- R6: With the enable at 1, the loaded word equals the shift register with every bit above the index cleared. An index of 31 keeps all bits, and an index of 15 clears bits 31:16.
- R7: `rx_full` rises in the cycle after the transfer cycle. A read of address 0 (`reg_rd` high) clears `rx_full` and `rx_overrun` at the next edge.
- R8: If a frame completes while `rx_full` is set and no data read happens in the same cycle, `rx_overrun` is set and the data register keeps its older word.
- R9: Changing the mask or length settings after a word has been loaded does not alter that word.
- R10: Strobes on consecutive clock cycles are all captured. This includes a strobe in the transfer cycle, which starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_edge | input | 1 | One-cycle strobe marking a sampling edge of the serial clock |
| sdi | input | 1 | Serial data, valid when `sclk_edge` is high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 clears the flags) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rx_full | output | 1 | Unread word present |
| rx_overrun | output | 1 | A frame was dropped while full |

## Verification
Length mode is swept over all 32 frame lengths, and explicit mode over all 32 indices with full-length frames. Random data is used, with the bench modelling the shift register across frames. Because stale bits from earlier frames sit above each new frame, a missing or off-by-one cut shows up as extra set bits. Two frames sent without a read separate "keep the old word" from "overwrite". Eight back-to-back strobes with a 4-bit frame separate a machine that accepts a strobe in the transfer cycle from one that drops it. Rewriting the mask after a load separates a latched word from a live-masked read path.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_XFER  = 2'd2
    } frame_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;

    localparam int FIELD_LSB   = 10;
    localparam int MASK_EN_BIT = 1;
endpackage

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
    import spi_rx_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_edge,
    input  logic          sdi,
    input  logic [IW-1:0] bpt,
    output logic [DW-1:0] shift_word,
    output logic          frame_done
);
    frame_state_t  state, state_nx;
    logic [IW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_XFER: begin
                if (sclk_edge) state_nx = (bpt == '0) ? ST_XFER : ST_SHIFT;
                else           state_nx = ST_IDLE;
            end
            ST_SHIFT: begin
                if (sclk_edge && (cnt + 1'b1 == bpt)) state_nx = ST_XFER;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_word <= '0;
            cnt        <= '0;
        end else if (sclk_edge) begin
            shift_word <= {shift_word[DW-2:0], sdi};
            cnt        <= (state == ST_SHIFT) ? cnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb frame_done = (state == ST_XFER);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (cnt < bpt));
    p_xfer_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && !sclk_edge) |=> (state == ST_IDLE));
endmodule

// File: rtl/spi_rx_cfg.sv
module spi_rx_cfg
    import spi_rx_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [IW-1:0] bpt,
    output logic [IW-1:0] top_idx,
    output logic          mask_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bpt     <= '0;
            top_idx <= '0;
            mask_en <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_CTRL) bpt <= wdata[FIELD_LSB +: IW];
            if (addr == ADDR_MASK) begin
                top_idx <= wdata[FIELD_LSB +: IW];
                mask_en <= wdata[MASK_EN_BIT];
            end
        end
    end

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(top_idx) && $stable(mask_en) && $stable(bpt)));
endmodule

// File: rtl/spi_rx_zext.sv
module spi_rx_zext #(
    parameter int DW = 32,
    parameter int IW = $clog2(DW)
) (
    input  logic [DW-1:0] word,
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] out
);
    logic [DW-1:0] keep;

    for (genvar i = 0; i < DW; i++) begin : g_keep
        assign keep[i] = (idx >= IW'(i));
    end

    assign out = word & keep;
endmodule

// File: rtl/spi_rx_mask.sv
module spi_rx_mask
    import spi_rx_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_edge,
    input  logic          sdi,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          rx_full,
    output logic          rx_overrun
);
    logic [IW-1:0] bpt, top_idx, cut_idx;
    logic          mask_en, frame_done, rd_data, accept;
    logic [DW-1:0] shift_word, masked, rx_data;

    spi_rx_frame #(.DW(DW), .IW(IW)) u_frame (
        .clk(clk), .rst_n(rst_n), .sclk_edge(sclk_edge), .sdi(sdi),
        .bpt(bpt), .shift_word(shift_word), .frame_done(frame_done)
    );

    spi_rx_cfg #(.DW(DW), .IW(IW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .bpt(bpt), .top_idx(top_idx), .mask_en(mask_en)
    );

    assign cut_idx = mask_en ? top_idx : bpt;

    spi_rx_zext #(.DW(DW), .IW(IW)) u_zext (
        .word(shift_word), .idx(cut_idx), .out(masked)
    );

    assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
    assign accept  = frame_done && (!rx_full || rd_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_full    <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (rd_data) begin
                rx_full    <= 1'b0;
                rx_overrun <= 1'b0;
            end
            if (accept) begin
                rx_data <= masked;
                rx_full <= 1'b1;
            end else if (frame_done) begin
                rx_overrun <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = rx_data;
            ADDR_CTRL: reg_rdata[FIELD_LSB +: IW] = bpt;
            ADDR_MASK: begin
                reg_rdata[FIELD_LSB +: IW] = top_idx;
                reg_rdata[MASK_EN_BIT]     = mask_en;
            end
            default: reg_rdata = '0;
        endcase
    end

    p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !rx_full) |=> rx_full);
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !frame_done) |=> (!rx_full && !rx_overrun));
    p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_full && !rd_data) |=> (rx_overrun && $stable(rx_data)));
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_data));
    p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mask_en) |=> (((rx_data >> $past(top_idx)) >> 1) == '0));
endmodule

// File: tb/sim_spi_rx_mask.sv
module sim_spi_rx_mask;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_edge = 1'b0, sdi = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_full, rx_overrun;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] sh = '0;   // model of the shift register

    always #5 clk = ~clk;

    spi_rx_mask u0 (
        .clk(clk), .rst_n(rst_n), .sclk_edge(sclk_edge), .sdi(sdi),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    function automatic logic [31:0] cut(input logic [31:0] w, input int idx);
        logic [63:0] m = (64'd1 << (idx + 1)) - 64'd1;
        return w & m[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic send(input logic [31:0] w, input int nbits, input int gap);
        for (int b = nbits - 1; b >= 0; b--) begin
            @(negedge clk); sclk_edge = 1'b1; sdi = w[b];
            sh = {sh[30:0], w[b]};
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); sclk_edge = 1'b0;
            end
        end
        @(negedge clk); sclk_edge = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, w, exp;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d); check("R1 data", d, 32'h0);
        rd(2'd1, d); check("R1 ctrl", d, 32'h0);
        rd(2'd2, d); check("R1 mask", d, 32'h0);
        check("R1 flags", {30'd0, rx_full, rx_overrun}, 32'h0);
        // R2 / R3 reserved bits
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R2 mask layout", d, 32'h0000_7C02);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R3 ctrl layout", d, 32'h0000_7C00);
        // R4/R5 length mode sweep, all frame lengths
        wr(2'd2, 32'h0);
        for (int b = 0; b < 32; b++) begin
            wr(2'd1, b << 10);
            w = $urandom;
            send(w, b + 1, 1 + ($urandom % 2));
            exp = cut(sh, b);
            check("R7 full set", {31'd0, rx_full}, 32'd1);
            rd(2'd0, d); check("R5 R4 length mode", d, exp);
            check("R7 full cleared", {31'd0, rx_full}, 32'd0);
        end
        // R6 explicit mode sweep, full-length frames
        wr(2'd1, 31 << 10);
        for (int m = 0; m < 32; m++) begin
            wr(2'd2, (m << 10) | 32'h2);
            w = $urandom;
            send(w, 32, 1);
            rd(2'd0, d); check("R6 explicit mode", d, cut(sh, m));
        end
        // R6 directed: index 15 with short frame leaves stale bits below 16
        wr(2'd1, 7 << 10); wr(2'd2, (15 << 10) | 32'h2);
        send(32'hA5, 8, 1);
        rd(2'd0, d); check("R6 index 15", d, sh & 32'h0000_FFFF);
        // R9 mask changes after load
        send(32'h3C, 8, 1);
        exp = sh & 32'h0000_FFFF;
        wr(2'd2, 32'h2); wr(2'd1, 32'h0);
        rd(2'd0, d); check("R9 word kept after mask change", d, exp);
        // R8 overrun keeps the older word
        wr(2'd2, 32'h0); wr(2'd1, 7 << 10);
        send($urandom, 8, 1); exp = cut(sh, 7);
        send($urandom, 8, 2);
        check("R8 overrun flag", {31'd0, rx_overrun}, 32'd1);
        rd(2'd0, d); check("R8 older word", d, exp);
        check("R7 overrun cleared", {31'd0, rx_overrun}, 32'd0);
        // R10 back-to-back strobes, strobe in transfer cycle starts next frame
        wr(2'd1, 3 << 10);
        w = 32'h0000_00B6;
        send(w, 8, 0);
        check("R10 second frame seen", {31'd0, rx_overrun}, 32'd1);
        rd(2'd0, d); check("R10 first frame", d, 32'h0000_000B);
        finish_run();
    end
endmodule